// File: doc/BRIEF.md
# Self-Triggered Pulse Finder with Neighbour Clustering

This block takes one free-running stream of ADC samples for each of several adjacent channels, all running on the same sampling clock. It finds pulses in those streams without any external trigger. Each sample first has a programmable baseline subtracted. A pulse is recognised at its peak, once the peak has cleared a programmable threshold. The detector on that channel then stays quiet until the signal falls back under the threshold.

For every peak the block measures three things:
- a charge, which is a programmable window sum of samples;
- an arrival time, taken from the rising edge at half the peak height, interpolated to 1/16 of a sampling period against a free-running time counter;
- the charges of the two neighbouring channels, measured over the same window.

A channel whose charge beats both neighbours becomes the centre of a cluster. For that centre the block writes one record into a small output FIFO, which drains over a valid/ready stream toward a data link. Records that cannot be stored are counted in a saturating loss counter.

Top module: `hit_clusterer`

## Requirements
- R1: Each sample is reduced by `baseline`. A raw value at or below `baseline` becomes 0. All the other rules below act on these reduced values.
- R2: A channel declares a hit on sample p when all four conditions hold: the channel is armed, v[p] >= `threshold`, v[p] >= v[p-1], and v[p] > v[p+1]. On a flat top this places the hit on the last sample of the plateau.
- R3: A hit disarms its channel. The channel re-arms when a reduced sample below `threshold` reaches the peak position, so a second local maximum that stays above threshold gives no hit.
- R4: The charge of every channel is the sum of the L most recent samples, ending at v[p+1]. L is `sum_len` clamped to the range 2 to 8, so 0 or 1 act as 2 and any value above 8 acts as 8.
- R5: Let h = floor(v[p]/2). The block searches j = 1..7 for the smallest j with v[p-j] < h. The record then carries the time of sample p-j, which is time_in of that sample, together with frac = min(15, floor(16*(h - v[p-j]) / (v[p-j+1] - v[p-j]))). If no such j exists, the time is that of sample p-7 and frac is 0.
- R6: A hit channel becomes a cluster centre only if its charge is strictly greater than its lower-index neighbour's charge and at least equal to its higher-index neighbour's charge. A missing edge neighbour counts as 0. Charge on a neighbour that has no hit of its own still counts.
- R7: At most one record is stored per cycle, from the lowest-index centre. In any cycle where a centre's record is not stored, `drop_count` rises by one, saturating at all ones.
- R8: `rec_data` is laid out from MSB to LSB as: channel (CW bits), integer time (TW bits), frac (4 bits), lower-neighbour charge, centre charge, higher-neighbour charge (QW = SW+3 bits each).
- R9: A record becomes visible on `rec_valid` at the second rising edge after the sample following the peak is presented.
- R10: The output FIFO holds DEPTH records. While `rec_valid` is high and `rec_ready` is low, the record holds steady. A centre found while the FIFO is full is lost and counted.
- R11: Reset clears the FIFO, the loss counter and the sample history, and arms every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samples | input | NCH*SW | One sample per channel each cycle, channel 0 in the low bits |
| time_in | input | TW | Free-running time counter value of the current samples, advancing by one per clock |
| threshold | input | SW | Hit threshold applied to reduced samples |
| baseline | input | SW | Value subtracted from every raw sample |
| sum_len | input | 4 | Charge window length, clamped to 2..8 |
| rec_valid | output | 1 | A cluster record is available |
| rec_ready | input | 1 | The consumer accepts the record |
| rec_data | output | CW+TW+4+3*QW | Cluster record |
| drop_count | output | DCW | Saturating count of cycles that lost a record |

## Verification
A peak only becomes known when the sample after it is registered, one edge after that sample is presented. The record is written into the FIFO at the next edge, so `rec_valid` rises two edges after the post-peak sample; the loss counter moves on that same writing edge. The bench's reference model reproduces this timing: it evaluates hits from the history held before each edge, updates its queue and counter at that edge, and compares the valid flag, the record and the counter at the following falling edge on every cycle. One directed case checks that `rec_valid` is still low one edge after the post-peak sample and high one edge later, with the hand-computed fields.

// File: rtl/hit_clusterer.sv
module hit_clusterer #(
  parameter int NCH = 4,
  parameter int SW = 10,
  parameter int TW = 16,
  parameter int DEPTH = 4,
  parameter int DCW = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int QW = SW + 3,
  localparam int RW = CW + TW + 4 + 3 * QW,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*SW-1:0] samples,
  input  logic [TW-1:0]     time_in,
  input  logic [SW-1:0]     threshold,
  input  logic [SW-1:0]     baseline,
  input  logic [3:0]        sum_len,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [RW-1:0]     rec_data,
  output logic [DCW-1:0]    drop_count
);

  logic [NCH-1:0]    hit, cent;
  logic [NCH*QW-1:0] qv, qlv, qrv;
  logic [NCH*TW-1:0] tv;
  logic [NCH*4-1:0]  fv;
  logic [TW-1:0]     t0;
  logic [3:0]        len;
  logic [CW-1:0]     sel;
  logic [RW-1:0]     rec;
  logic [RW-1:0]     mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [AW:0]       cnt;
  logic              full, push, pop, lost;

  assign len = (sum_len < 4'd2) ? 4'd2 : (sum_len > 4'd8) ? 4'd8 : sum_len;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0]   h [9];
    logic            armed, found;
    logic [SW-1:0]   raw, v, pk, half, lo, hi;
    logic [3:0]      jsel;
    logic [QW-1:0]   qsum, ql, qr;
    logic [SW+3:0]   quo;

    assign raw  = samples[c*SW +: SW];
    assign v    = (raw > baseline) ? raw - baseline : '0;
    assign pk   = h[1];
    assign half = pk >> 1;
    assign hit[c] = armed && (pk >= threshold) && (pk >= h[2]) && (pk > h[0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < 9; k++) h[k] <= '0;
        armed <= 1'b1;
      end else begin
        h[0] <= v;
        for (int k = 1; k < 9; k++) h[k] <= h[k-1];
        if (hit[c]) armed <= 1'b0;
        else if (pk < threshold) armed <= 1'b1;
      end
    end

    always_comb begin
      qsum = '0;
      for (int k = 0; k < 8; k++)
        if (4'(k) < len) qsum = qsum + QW'(h[k]);
      found = 1'b0;
      lo = '0;
      hi = '0;
      jsel = 4'd7;
      for (int j = 7; j >= 1; j--)
        if (h[j+1] < half) begin
          found = 1'b1;
          lo = h[j+1];
          hi = h[j];
          jsel = 4'(j);
        end
    end

    assign quo = found ? (((SW+4)'(half - lo)) << 4) / (SW+4)'(hi - lo) : '0;
    assign fv[c*4 +: 4]   = (quo > (SW+4)'(15)) ? 4'd15 : quo[3:0];
    assign tv[c*TW +: TW] = t0 - TW'(jsel) - TW'(1);
    assign qv[c*QW +: QW] = qsum;

    if (c == 0) begin : g_lo
      assign ql = '0;
    end else begin : g_lo
      assign ql = qv[(c-1)*QW +: QW];
    end
    if (c == NCH - 1) begin : g_hi
      assign qr = '0;
    end else begin : g_hi
      assign qr = qv[(c+1)*QW +: QW];
    end

    assign qlv[c*QW +: QW] = ql;
    assign qrv[c*QW +: QW] = qr;
    assign cent[c] = hit[c] && (qsum > ql) && (qsum >= qr);

    assert_no_rehit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit[c] |=> !hit[c]);
  end

  always_comb begin
    sel = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (cent[c]) sel = CW'(c);
  end

  assign rec = {sel, tv[sel*TW +: TW], fv[sel*4 +: 4],
                qlv[sel*QW +: QW], qv[sel*QW +: QW], qrv[sel*QW +: QW]};

  assign full      = (cnt == (AW+1)'(DEPTH));
  assign push      = (|cent) && !full;
  assign lost      = ($countones(cent) > 1) || ((|cent) && full);
  assign rec_valid = (cnt != '0);
  assign pop       = rec_valid && rec_ready;
  assign rec_data  = mem[rp];

  always_ff @(posedge clk)
    if (push) mem[wp] <= rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      t0 <= '0;
      drop_count <= '0;
    end else begin
      t0 <= time_in;
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      if (lost && (drop_count != '1)) drop_count <= drop_count + 1'b1;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_data));

  assert_drop_monotone_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drop_count >= $past(drop_count));

  assert_loss_counted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lost && (drop_count != '1) |=> drop_count == $past(drop_count) + 1'b1);

  assert_push_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> rec_valid);

endmodule

// File: tb/tb_hit_clusterer.sv
module tb_hit_clusterer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4, SW = 10, TW = 16, DEPTH = 4, DCW = 3;
  localparam int CW = 2, QW = SW + 3, RW = CW + TW + 4 + 3 * QW;
  localparam int DMAX = (1 << DCW) - 1;

  logic clk = 0, rst_n = 0, rec_ready = 1, rec_valid;
  logic [NCH*SW-1:0] samples = '0;
  logic [TW-1:0] time_in = '0;
  logic [SW-1:0] threshold = 10'd150, baseline = '0;
  logic [3:0] sum_len = 4'd2;
  logic [RW-1:0] rec_data;
  logic [DCW-1:0] drop_count;

  int checks = 0, fails = 0, tcount = 0, done = 0;
  string phase = "R11";

  hit_clusterer #(.NCH(NCH), .SW(SW), .TW(TW), .DEPTH(DEPTH), .DCW(DCW)) dut (
    .clk(clk), .rst_n(rst_n), .samples(samples), .time_in(time_in),
    .threshold(threshold), .baseline(baseline), .sum_len(sum_len),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
    .drop_count(drop_count));

  always #(CLK_PERIOD/2) clk = ~clk;

  int mh [NCH][9];
  int marm [NCH];
  int mt0, mdrop, mpush;
  logic [RW-1:0] mq [$];

  function automatic void interp(input int c, output int t, output int f);
    int half, lo, hi, jj;
    bit found;
    half = mh[c][1] / 2; found = 0; lo = 0; hi = 0; jj = 7;
    for (int j = 1; j <= 7; j++)
      if (!found && mh[c][1+j] < half) begin
        found = 1; lo = mh[c][1+j]; hi = mh[c][j]; jj = j;
      end
    if (found) begin
      t = (mt0 - (jj + 1)) & 16'hFFFF;
      f = ((half - lo) * 16) / (hi - lo);
      if (f > 15) f = 15;
    end else begin
      t = (mt0 - 8) & 16'hFFFF;
      f = 0;
    end
  endfunction

  always @(posedge clk) begin : model
    int len, sel, ncent, pk, ql, qr, t, f, raw;
    int qs [NCH];
    int hv [NCH];
    int ce [NCH];
    bit full;
    logic [RW-1:0] r;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        marm[c] = 1;
        for (int k = 0; k < 9; k++) mh[c][k] = 0;
      end
      mt0 = 0; mdrop = 0; mq.delete();
    end else begin
      len = int'(sum_len);
      if (len < 2) len = 2;
      if (len > 8) len = 8;
      for (int c = 0; c < NCH; c++) begin
        pk = mh[c][1];
        hv[c] = (marm[c] != 0 && pk >= int'(threshold) && pk >= mh[c][2] && pk > mh[c][0]) ? 1 : 0;
        qs[c] = 0;
        for (int k = 0; k < len; k++) qs[c] += mh[c][k];
      end
      ncent = 0; sel = -1;
      for (int c = 0; c < NCH; c++) begin
        ql = (c > 0) ? qs[c-1] : 0;
        qr = (c < NCH - 1) ? qs[c+1] : 0;
        ce[c] = (hv[c] != 0 && qs[c] > ql && qs[c] >= qr) ? 1 : 0;
        if (ce[c] != 0) begin
          ncent++;
          if (sel < 0) sel = c;
        end
      end
      full = (mq.size() >= DEPTH);
      r = '0;
      if (sel >= 0) begin
        interp(sel, t, f);
        ql = (sel > 0) ? qs[sel-1] : 0;
        qr = (sel < NCH - 1) ? qs[sel+1] : 0;
        r = {CW'(sel), TW'(t), 4'(f), QW'(ql), QW'(qs[sel]), QW'(qr)};
      end
      if (mq.size() > 0 && rec_ready) void'(mq.pop_front());
      if (sel >= 0 && !full) begin mq.push_back(r); mpush++; end
      if ((ncent > 1 || (sel >= 0 && full)) && mdrop < DMAX) mdrop++;
      for (int c = 0; c < NCH; c++) begin
        if (hv[c] != 0) marm[c] = 0;
        else if (mh[c][1] < int'(threshold)) marm[c] = 1;
        for (int k = 8; k >= 1; k--) mh[c][k] = mh[c][k-1];
        raw = int'(samples[c*SW +: SW]);
        mh[c][0] = (raw > int'(baseline)) ? raw - int'(baseline) : 0;
      end
      mt0 = int'(time_in);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rec_valid !== (mq.size() > 0) || (mq.size() > 0 && rec_data !== mq[0])) begin
        fails++;
        $display("FAIL %s record: act v=%0b %h exp v=%0b %h", phase, rec_valid, rec_data,
                 mq.size() > 0, (mq.size() > 0) ? mq[0] : '0);
      end
      checks++;
      if (int'(drop_count) != mdrop) begin
        fails++;
        $display("FAIL %s drop_count: act %0d exp %0d", phase, drop_count, mdrop);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int a0, input int a1, input int a2, input int a3);
    samples = {SW'(a3), SW'(a2), SW'(a1), SW'(a0)};
    time_in = TW'(tcount);
    tcount++;
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  task automatic pulse(input int ch, input int a[$]);
    foreach (a[i]) cyc(ch == 0 ? a[i] : 0, ch == 1 ? a[i] : 0, ch == 2 ? a[i] : 0, ch == 3 ? a[i] : 0);
  endtask

  task automatic count_since(input string tag, input int base, input int exp);
    idle(4);
    chk(tag, 64'(mpush - base), 64'(exp));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    int base, tmark;
    logic [RW-1:0] er;
    idle(3);
    chk("R11 valid in reset", 64'(rec_valid), 0);
    chk("R11 drop in reset", 64'(drop_count), 0);
    rst_n = 1;
    idle(2);
    chk("R11 valid after reset", 64'(rec_valid), 0);

    phase = "R1"; base = mpush; baseline = 10'd100; threshold = 10'd100;
    idle(2);
    pulse(0, '{50, 20, 100, 150, 300, 400, 250, 120, 100, 100, 100});
    pulse(1, '{180, 100, 100});
    count_since("R1 hits after baseline", base, 1);
    baseline = '0; threshold = 10'd150; idle(2);

    phase = "R2"; base = mpush;
    pulse(1, '{0, 50, 200, 400, 300, 100, 0, 0});
    pulse(1, '{0, 0, 160, 160, 0, 0});
    count_since("R2 single and plateau", base, 2);

    phase = "R3"; base = mpush;
    pulse(1, '{0, 300, 500, 300, 450, 200, 50, 0, 0});
    pulse(1, '{0, 300, 0, 0});
    count_since("R3 re-arm", base, 2);

    phase = "R4"; base = mpush;
    sum_len = 4'd0; pulse(2, '{0, 100, 300, 200, 100, 50, 0, 0, 0, 0});
    sum_len = 4'd5; pulse(2, '{0, 100, 300, 200, 100, 50, 0, 0, 0, 0});
    sum_len = 4'd12; pulse(2, '{0, 100, 300, 200, 100, 50, 0, 0, 0, 0});
    count_since("R4 windows", base, 3);
    sum_len = 4'd2; idle(2);

    phase = "R5"; base = mpush;
    pulse(3, '{0, 300, 310, 320, 330, 340, 350, 360, 370, 380, 390, 400, 0, 0});
    pulse(3, '{0, 100, 400, 0, 0});
    count_since("R5 slow and fast", base, 2);

    phase = "R6"; base = mpush;
    cyc(0, 100, 200, 0); cyc(0, 300, 500, 0); cyc(0, 100, 200, 0); idle(3);
    cyc(100, 100, 0, 0); cyc(300, 300, 0, 0); idle(3);
    cyc(0, 0, 140, 0); cyc(0, 200, 140, 0); cyc(0, 0, 140, 0); idle(3);
    count_since("R6 centre choice", base, 2);

    phase = "R7"; base = mpush;
    cyc(300, 0, 300, 0); idle(2);
    count_since("R7 one record", base, 1);
    chk("R7 loss counted", 64'(drop_count), 1);

    phase = "R9"; rec_ready = 0;
    idle(1);
    cyc(0, 0, 100, 0);
    tmark = tcount - 1;
    cyc(0, 0, 400, 0);
    cyc(0, 0, 0, 0);
    chk("R9 not yet valid", 64'(rec_valid), 0);
    cyc(0, 0, 0, 0);
    chk("R9 valid two edges later", 64'(rec_valid), 1);
    er = {2'd2, TW'(tmark), 4'd5, 13'd0, 13'd400, 13'd0};
    phase = "R8";
    chk("R8 record fields", 64'(rec_data), 64'(er));
    rec_ready = 1; idle(3);

    phase = "R10"; rec_ready = 0;
    for (int i = 0; i < 6; i++) pulse(3, '{0, 300, 0, 0});
    chk("R10 drops when full", 64'(drop_count), 3);
    for (int i = 0; i < 6; i++) pulse(3, '{0, 300, 0, 0});
    chk("R10 drop saturates", 64'(drop_count), 64'(DMAX));
    chk("R10 valid held", 64'(rec_valid), 1);
    rec_ready = 1; idle(8);
    chk("R10 drained", 64'(rec_valid), 0);
    for (int i = 0; i < 24; i++) begin
      rec_ready = i[0];
      cyc(0, (i % 3 == 1) ? 300 : 0, 0, (i % 4 == 1) ? 250 : 0);
    end
    rec_ready = 1; idle(10);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: act running exp finished");
      summary();
      $finish;
    end
  end
endmodule